// File: doc/BRIEF.md
# Lane-Split Logical Left Shifter

This block shifts a 24-bit word left by one scalar amount. At runtime the word can be cut into up to three independent lanes. Two gate bits switch on candidate cut points that sit at the eight-bit seams inside the word. All lanes share the same shift amount. Each lane shifts its own bits and loses whatever leaves its top edge. Zeros fill each lane from its own bottom edge, so no bit ever passes through an active cut into the lane above it.

The block is used in a SIMD datapath where one shifter serves a full-width scalar operation, a mix of a 16-bit lane and an 8-bit lane, or three byte lanes. The lane layout is set per operation by the gate vector. The block is purely combinational. It has no clock, no reset and no storage, and the result is valid in the same cycle as its operands.

Top module: `lane_split_lshift`

## Requirements
- R1: With gate value 2'b00 there is a single 24-bit lane. The output equals the input word shifted left by the amount and truncated to 24 bits.
- R2: With gate value 2'b01 (bit 0 set, which enables the cut at bit 8), bits 7..0 form one lane and bits 23..8 form a second lane. Each lane is shifted separately and truncated to its own width.
- R3: With gate value 2'b10 (bit 1 set, which enables the cut at bit 16), bits 15..0 form one lane and bits 23..16 form a second lane. Each lane is shifted separately and truncated to its own width.
- R4: With gate value 2'b11 there are three byte lanes: 7..0, 15..8 and 23..16. Each is shifted by the same amount and truncated to 8 bits.
- R5: For a nonzero amount, the bottom bit of every lane is zero at the output. This covers bit 0 and the bit just above each active cut, so nothing crosses an active cut.
- R6: A lane whose width is less than or equal to the amount outputs all zeros. In particular, amounts 24 to 31 give an all-zero output for every gate value.
- R7: An amount of zero passes the input word through unchanged for every gate value.
- R8: The output follows any change of data, amount or gates with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 24 | Word to be shifted |
| shamt_i | input | 5 | Left shift amount, 0 to 31, shared by all lanes |
| gate_i | input | 2 | Cut enables: bit 0 for the cut at bit 8, bit 1 for the cut at bit 16 |
| data_o | output | 24 | Shifted word, lane by lane |

## Verification
Lane isolation at an active cut and the zeroing of a lane that has overflowed can apply in the same evaluation, in adjacent lanes. Gate value 2'b10 with amount 8 shows this: the upper byte lane must go to zero, while the 16-bit lane beneath it keeps its low byte, now moved into bits 15..8. The bench provokes this by sweeping every gate value against the amounts 0, 7, 8, 15, 16, 23, 24 and 31 with all-ones, alternating and random data. It judges each result word against a behavioural per-lane model that extracts, shifts, masks and reassembles each lane on its own.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

    // Default geometry: three byte lanes, 5-bit scalar amount
    localparam int LANE_W_DEF    = 8;
    localparam int NUM_LANES_DEF = 3;
    localparam int SHAMT_W_DEF   = 5;

endpackage

// File: rtl/lsl_lane_floor.sv
// For every bit position, find the index of the lowest bit of the lane
// that contains it, given which cuts are enabled.
module lsl_lane_floor #(
    parameter int LANE_W    = lsl_pkg::LANE_W_DEF,
    parameter int NUM_LANES = lsl_pkg::NUM_LANES_DEF,
    localparam int WIDTH    = LANE_W * NUM_LANES,
    localparam int IDX_W    = $clog2(WIDTH)
) (
    input  logic [NUM_LANES-2:0]         gate_i,
    output logic [WIDTH-1:0][IDX_W-1:0]  floor_o
);

    logic [WIDTH-1:0][IDX_W-1:0] floor_d;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            floor_d[i] = '0;
            // cuts are visited bottom-up, so the last hit is the highest cut at or below i
            for (int k = 1; k < NUM_LANES; k++) begin
                if (gate_i[k-1] && (k * LANE_W <= i)) begin
                    floor_d[i] = IDX_W'(k * LANE_W);
                end
            end
        end
    end

    assign floor_o = floor_d;

endmodule

// File: rtl/lsl_lane_mask.sv
// Per-bit keep mask: a bit of the full-width shift survives only if its
// source bit came from inside the same lane.
module lsl_lane_mask #(
    parameter int WIDTH   = 24,
    parameter int SHAMT_W = 5,
    localparam int IDX_W  = $clog2(WIDTH)
) (
    input  logic [SHAMT_W-1:0]           shamt_i,
    input  logic [WIDTH-1:0][IDX_W-1:0]  floor_i,
    output logic [WIDTH-1:0]             keep_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        int room_d;
        always_comb begin
            room_d    = g - int'(floor_i[g]);
            keep_o[g] = (int'(shamt_i) <= room_d);
        end
    end

endmodule

// File: rtl/lane_split_lshift.sv
module lane_split_lshift #(
    parameter int LANE_W    = lsl_pkg::LANE_W_DEF,
    parameter int NUM_LANES = lsl_pkg::NUM_LANES_DEF,
    parameter int SHAMT_W   = lsl_pkg::SHAMT_W_DEF,
    localparam int WIDTH    = LANE_W * NUM_LANES,
    localparam int IDX_W    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]     data_i,
    input  logic [SHAMT_W-1:0]   shamt_i,
    input  logic [NUM_LANES-2:0] gate_i,
    output logic [WIDTH-1:0]     data_o
);

    typedef struct packed {
        logic [WIDTH-1:0] wide;
        logic [WIDTH-1:0] keep;
        logic [WIDTH-1:0] res;
    } shift_st_t;

    shift_st_t                   st_d;
    logic [WIDTH-1:0][IDX_W-1:0] floor_w;
    logic [WIDTH-1:0]            keep_w;

    lsl_lane_floor #(
        .LANE_W    (LANE_W),
        .NUM_LANES (NUM_LANES)
    ) u_floor (
        .gate_i  (gate_i),
        .floor_o (floor_w)
    );

    lsl_lane_mask #(
        .WIDTH   (WIDTH),
        .SHAMT_W (SHAMT_W)
    ) u_mask (
        .shamt_i (shamt_i),
        .floor_i (floor_w),
        .keep_o  (keep_w)
    );

    always_comb begin
        st_d      = '0;
        st_d.wide = data_i << shamt_i;
        st_d.keep = keep_w;
        st_d.res  = st_d.wide & st_d.keep;
    end

    assign data_o = st_d.res;

endmodule

// File: rtl/lane_split_lshift_chk.sv
module lane_split_lshift_chk #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 3,
    parameter int SHAMT_W   = 5,
    localparam int WIDTH    = LANE_W * NUM_LANES
) (
    input logic [WIDTH-1:0]     data_i,
    input logic [SHAMT_W-1:0]   shamt_i,
    input logic [NUM_LANES-2:0] gate_i,
    input logic [WIDTH-1:0]     data_o
);

    always_comb begin
        // R1
        whole_word_chk: assert ((gate_i != '0) || (data_o == WIDTH'(data_i << shamt_i)))
            else $error("whole-word shift mismatch");
        // R7
        zero_amount_chk: assert ((shamt_i != '0) || (data_o == data_i))
            else $error("zero amount not a pass-through");
        // R6
        full_overflow_chk: assert ((int'(shamt_i) < WIDTH) || (data_o == '0))
            else $error("overflowing amount left bits set");
        // R4
        byte_lane_over_chk: assert (!((&gate_i) && (int'(shamt_i) >= LANE_W)) || (data_o == '0))
            else $error("byte lanes not cleared on overflow");
        // R5
        bottom_bit_chk: assert ((shamt_i == '0) || (data_o[0] == 1'b0))
            else $error("bit 0 not zero-filled");
        for (int k = 1; k < NUM_LANES; k++) begin
            // R5
            cut_leak_chk: assert (!(gate_i[k-1] && (shamt_i != '0)) || (data_o[k*LANE_W] == 1'b0))
                else $error("bit leaked across active cut");
        end
    end

endmodule

bind lane_split_lshift lane_split_lshift_chk #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES),
    .SHAMT_W   (SHAMT_W)
) u_chk (
    .data_i  (data_i),
    .shamt_i (shamt_i),
    .gate_i  (gate_i),
    .data_o  (data_o)
);

// File: tb/lane_split_lshift_tb_top.sv
module lane_split_lshift_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 24;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data;
    logic [4:0]    shamt;
    logic [1:0]    gate;
    logic [W-1:0]  dout;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_split_lshift dut_i (
        .data_i  (data),
        .shamt_i (shamt),
        .gate_i  (gate),
        .data_o  (dout)
    );

    // Behavioural lane model: extract each lane, shift, mask, reinsert
    function automatic logic [W-1:0] model(input logic [W-1:0] d, input int s, input logic [1:0] g);
        longint res = 0;
        int lo = 0;
        for (int k = 1; k <= 3; k++) begin
            if (k == 3 || g[k-1]) begin
                int wd = k*8 - lo;
                longint msk = (longint'(1) << wd) - 1;
                longint ln = (longint'(d) >> lo) & msk;
                longint sh = (s >= wd) ? 0 : ((ln << s) & msk);
                res = res | (sh << lo);
                lo = k*8;
            end
        end
        return W'(res);
    endfunction

    function automatic string gate_tag(input logic [1:0] g);
        case (g)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gate=%b shamt=%0d data=%h got %h expected %h",
                     tag, gate, shamt, data, act, exp);
        end
    endtask

    // drive on the falling edge, sample a little later, away from the rising edge
    task automatic apply(input logic [W-1:0] d, input int s, input logic [1:0] g);
        @(negedge clk);
        data = d; shamt = 5'(s); gate = g;
        #1;
        check(gate_tag(g), dout, model(d, s, g));
        if (s == 0) check("R7", dout, d);
        if (s >= 24) check("R6", dout, '0);
        if (s != 0) begin
            check("R5", {23'd0, dout[0]}, '0);
            if (g[0]) check("R5", {23'd0, dout[8]}, '0);
            if (g[1]) check("R5", {23'd0, dout[16]}, '0);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
    end

    initial begin
        int amts[8] = '{0, 7, 8, 15, 16, 23, 24, 31};
        logic [W-1:0] pats[3];
        pats[0] = 24'hFFFFFF;
        pats[1] = 24'hA5C33C;
        pats[2] = 24'h000001;
        data = '0; shamt = '0; gate = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle state: all-zero operands give a zero word (R7)
        check("R7", dout, '0);

        for (int gi = 0; gi < 4; gi++)
            for (int ai = 0; ai < 8; ai++)
                for (int pi = 0; pi < 3; pi++)
                    apply(pats[pi], amts[ai], 2'(gi));

        // adjacent-lane case: upper byte cleared, 16-bit lane keeps its low byte (R3)
        apply(24'hFFFFFF, 8, 2'b10);
        check("R3", dout, 24'h00FF00);

        for (int r = 0; r < 300; r++)
            apply(W'($urandom), $urandom_range(0, 31), 2'($urandom));

        // R8: output follows inputs with no clock edge in between
        @(negedge clk);
        data = 24'h123456; shamt = 5'd4; gate = 2'b11;
        #1 check("R8", dout, model(24'h123456, 4, 2'b11));
        gate = 2'b00;
        #1 check("R8", dout, model(24'h123456, 4, 2'b00));
        shamt = 5'd12;
        #1 check("R8", dout, model(24'h123456, 12, 2'b00));
        data = 24'hFEDCBA;
        #1 check("R8", dout, model(24'hFEDCBA, 12, 2'b00));
        done = 1;
    end

    initial begin
        wait (done || cycles >= WATCHDOG);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected under %0d", cycles, WATCHDOG);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule